// File: doc/BRIEF.md
# Pulsed Power Sequencer

This controller moves the analog bias of a row of pixel columns between a nominal operating level and a low-power saving level. An external power-pulse request decides the target. When the request goes high the columns are brought up one at a time, lowest index first, with a programmable number of idle cycles between steps, so the supply sees a series of small load steps rather than one large one. When the request drops the columns are released in the reverse order with a separately programmable spacing.

The enabled set of columns is always a thermometer code: the number of enabled columns grows or shrinks by one at each step. Once every column is enabled, a programmable settle interval runs. At the end of that interval a ready flag tells the acquisition logic that the front-ends can be trusted. A configuration bit chooses what a disabled column gets. Either it sits at low bias, or its analog supply is removed entirely. If the request is withdrawn part way through power-up, the controller turns round at once and releases the columns already enabled.

Top module: `pulse_power_sequencer`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, no column is enabled, ready is low, and the power-off vector equals the full-cut bit replicated across all columns.
- R2: A high request seen in the all-off state enables column 0 at the next clock edge. Column k is then enabled (upGap+1)*k edges after column 0. Columns are always enabled lowest index first, so colEnable holds 2^n-1 when n columns are on.
- R3: A low request seen with all columns on disables the highest column at the next clock edge. The remaining columns are released in descending order, one every downGap+1 edges, until none is enabled.
- R4: Ready rises settleTime edges after the edge that enables the last column. While ready is high, every column is enabled. Ready falls at the edge where the power-down begins.
- R5: A low request during power-up disables the highest enabled column at the next edge. The rest are released in descending order at the power-down spacing. If only column 0 was on, everything is off after that edge.
- R6: A high request during power-down has no effect until all columns are off. After that, the next edge with the request high enables column 0.
- R7: Bit i of colPowerOff is high exactly when fullCut is high and column i is not enabled. With fullCut low, every disabled column stays at low bias and colPowerOff is all zero.
- R8: At most one column changes state at any clock edge.
- R9: With upGap zero, the columns are enabled on consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseReq | input | 1 | External power-pulse request: 1 = power up, 0 = enter saving state |
| fullCut | input | 1 | 1 = disabled columns lose analog power, 0 = they sit at low bias |
| upGap | input | CNT_W | Idle cycles between successive column enables |
| downGap | input | CNT_W | Idle cycles between successive column releases |
| settleTime | input | CNT_W | Cycles from the last column enable to ready |
| colEnable | output | NUM_COLS | Per-column nominal-bias enable, thermometer coded |
| colPowerOff | output | NUM_COLS | Per-column analog power removal |
| ready | output | 1 | All columns enabled and settled |

## Verification
The assertions assume that pulseReq is already synchronous to clk. They also assume that the three timing values do not change while a ramp or the settle interval is running, since a change mid-count would move the next step. The stimulus meets both assumptions: every input is changed on the falling edge, and new spacing and settle values are loaded only while the block is fully off. Early withdrawal of the request, and a request raised again during power-down, are applied on chosen cycles so that the turn-round paths are exercised.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_RAMP_UP,
    ST_ON,
    ST_RAMP_DOWN
  } seqState_t;

  // Strobes from the sequencing control to the column datapath.
  typedef struct packed {
    logic shiftUp;    // enable one more column
    logic shiftDown;  // release the highest enabled column
    logic clrCnt;     // restart the spacing/settle counter
    logic incCnt;     // advance the spacing/settle counter
  } seqStrobe_t;

endpackage

// File: rtl/pulse_seq_datapath.sv
module pulse_seq_datapath
  import pulse_seq_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [CNT_W-1:0]    upGap,
  input  logic [CNT_W-1:0]    downGap,
  input  logic [CNT_W-1:0]    settleTime,
  output logic [NUM_COLS-1:0] colEnable,
  output logic                upHit,
  output logic                downHit,
  output logic                settleHit,
  output logic                atLastStep,
  output logic                atFirstStep
);

  localparam int IDX_W = $clog2(NUM_COLS + 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;   // number of columns currently enabled
  logic [NUM_COLS-1:0] colNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clrCnt) begin
      cnt <= '0;
    end else if (strobe.incCnt) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strobe.shiftUp) begin
      idx <= idx + 1'b1;
    end else if (strobe.shiftDown) begin
      idx <= idx - 1'b1;
    end
  end

  generate
    if (NUM_COLS == 1) begin : gSingle
      always_comb begin
        colNext = colEnable;
        if (strobe.shiftUp)   colNext = 1'b1;
        if (strobe.shiftDown) colNext = 1'b0;
      end
    end else begin : gMulti
      always_comb begin
        colNext = colEnable;
        if (strobe.shiftUp)   colNext = {colEnable[NUM_COLS-2:0], 1'b1};
        if (strobe.shiftDown) colNext = {1'b0, colEnable[NUM_COLS-1:1]};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) colEnable <= '0;
    else       colEnable <= colNext;
  end

  assign upHit       = (cnt == upGap);
  assign downHit     = (cnt == downGap);
  assign settleHit   = (cnt == settleTime);
  assign atLastStep  = (idx == IDX_W'(NUM_COLS - 1));
  assign atFirstStep = (idx == IDX_W'(1));

  // R2: the enabled set is always a thermometer code from column 0.
  assert_thermometer_R2: assert property (@(posedge clk) disable iff (!rstN)
    (({1'b0, colEnable} + {{NUM_COLS{1'b0}}, 1'b1}) & {1'b0, colEnable}) == '0);

  // R8: one column at most changes per edge.
  assert_single_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(colEnable ^ $past(colEnable)) <= 1);

  // R2: the column counter tracks the enabled vector.
  assert_index_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    int'(idx) == $countones(colEnable));

endmodule

// File: rtl/pulse_seq_control.sv
module pulse_seq_control
  import pulse_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pulseReq,
  input  logic       upHit,
  input  logic       downHit,
  input  logic       settleHit,
  input  logic       atLastStep,
  input  logic       atFirstStep,
  output seqStrobe_t strobe,
  output seqState_t  state,
  output logic       ready
);

  seqState_t nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_OFF: begin
        if (pulseReq) begin
          strobe.shiftUp = 1'b1;
          strobe.clrCnt  = 1'b1;
          nextState      = atLastStep ? ST_ON : ST_RAMP_UP;
        end
      end
      ST_RAMP_UP: begin
        if (!pulseReq) begin
          strobe.shiftDown = 1'b1;
          strobe.clrCnt    = 1'b1;
          nextState        = atFirstStep ? ST_OFF : ST_RAMP_DOWN;
        end else if (upHit) begin
          strobe.shiftUp = 1'b1;
          strobe.clrCnt  = 1'b1;
          nextState      = atLastStep ? ST_ON : ST_RAMP_UP;
        end else begin
          strobe.incCnt = 1'b1;
        end
      end
      ST_ON: begin
        if (!pulseReq) begin
          strobe.shiftDown = 1'b1;
          strobe.clrCnt    = 1'b1;
          nextState        = atFirstStep ? ST_OFF : ST_RAMP_DOWN;
        end else if (!settleHit) begin
          strobe.incCnt = 1'b1;
        end
      end
      ST_RAMP_DOWN: begin
        if (downHit) begin
          strobe.shiftDown = 1'b1;
          strobe.clrCnt    = 1'b1;
          nextState        = atFirstStep ? ST_OFF : ST_RAMP_DOWN;
        end else begin
          strobe.incCnt = 1'b1;
        end
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  assign ready = (state == ST_ON) && settleHit;

  // R5: a withdrawn request during power-up turns the ramp round at once.
  assert_reverse_on_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAMP_UP && !pulseReq) |=> (state == ST_RAMP_DOWN || state == ST_OFF));

  // R6: power-down is never cut short by a new request.
  assert_down_completes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAMP_DOWN && pulseReq) |=> (state == ST_RAMP_DOWN || state == ST_OFF));

endmodule

// File: rtl/pulse_power_sequencer.sv
module pulse_power_sequencer
  import pulse_seq_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pulseReq,
  input  logic                fullCut,
  input  logic [CNT_W-1:0]    upGap,
  input  logic [CNT_W-1:0]    downGap,
  input  logic [CNT_W-1:0]    settleTime,
  output logic [NUM_COLS-1:0] colEnable,
  output logic [NUM_COLS-1:0] colPowerOff,
  output logic                ready
);

  seqStrobe_t strobe;
  seqState_t  state;
  logic upHit, downHit, settleHit, atLastStep, atFirstStep;

  pulse_seq_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .pulseReq    (pulseReq),
    .upHit       (upHit),
    .downHit     (downHit),
    .settleHit   (settleHit),
    .atLastStep  (atLastStep),
    .atFirstStep (atFirstStep),
    .strobe      (strobe),
    .state       (state),
    .ready       (ready)
  );

  pulse_seq_datapath #(
    .NUM_COLS (NUM_COLS),
    .CNT_W    (CNT_W)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .upGap       (upGap),
    .downGap     (downGap),
    .settleTime  (settleTime),
    .colEnable   (colEnable),
    .upHit       (upHit),
    .downHit     (downHit),
    .settleHit   (settleHit),
    .atLastStep  (atLastStep),
    .atFirstStep (atFirstStep)
  );

  assign colPowerOff = ~colEnable & {NUM_COLS{fullCut}};

  // R4: ready only with the full column set on.
  assert_ready_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (&colEnable));

  // R3: the idle state holds every column released.
  assert_off_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF) |-> (colEnable == '0));

  // R3: during power-down no column is newly enabled.
  assert_down_no_growth_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_RAMP_DOWN) |-> ((colEnable & ~$past(colEnable)) == '0));

endmodule

// File: tb/pulse_power_sequencer_test.sv
module pulse_power_sequencer_test;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN, pulseReq, fullCut;
  logic [7:0] upGap, downGap, settleTime;
  logic [N-1:0] colEnable, colPowerOff;
  logic ready;

  int checks = 0;
  int errors = 0;
  int prevOnes = 0;

  always #2 clk = ~clk;

  pulse_power_sequencer #(.NUM_COLS(N), .CNT_W(8)) uut (
    .clk(clk), .rstN(rstN), .pulseReq(pulseReq), .fullCut(fullCut),
    .upGap(upGap), .downGap(downGap), .settleTime(settleTime),
    .colEnable(colEnable), .colPowerOff(colPowerOff), .ready(ready)
  );

  // {upGap, downGap, settle, fullCut, readyAt(16), offAt(16)}
  localparam logic [63:0] VEC [0:3] = '{
    {8'd0, 8'd1, 8'd0, 8'd1, 16'd8,  16'd15},
    {8'd2, 8'd0, 8'd3, 8'd0, 16'd25, 16'd8},
    {8'd1, 8'd3, 8'd5, 8'd1, 16'd20, 16'd29},
    {8'd4, 8'd2, 8'd1, 8'd0, 16'd37, 16'd22}
  };

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int thermo(input int n);
    return (1 << n) - 1;
  endfunction

  task automatic checkOutputs(input string tag, input int cnt, input bit rdy);
    int nowOnes;
    checkEq(tag, int'(colEnable), thermo(cnt));
    checkEq("R4 ready", int'(ready), int'(rdy));
    checkEq("R7 power-off vector", int'(colPowerOff),
            fullCut ? (~thermo(cnt) & thermo(N)) : 0);
    nowOnes = $countones(colEnable);
    checkEq("R8 single step", int'((nowOnes - prevOnes <= 1) && (prevOnes - nowOnes <= 1)), 1);
    prevOnes = nowOnes;
  endtask

  task automatic runUp(input int first, input int last, input string tag);
    pulseReq = 1'b1;
    for (int t = first; t <= last; t++) begin
      int cnt;
      int tLast;
      @(negedge clk);
      cnt = 1 + (t - 1) / (int'(upGap) + 1);
      if (cnt > N) cnt = N;
      tLast = 1 + (N - 1) * (int'(upGap) + 1);
      checkOutputs(tag, cnt, t >= tLast + int'(settleTime));
    end
  endtask

  task automatic runDown(input int startCnt, input int last, input string tag, input bit raise);
    pulseReq = 1'b0;
    for (int t = 1; t <= last; t++) begin
      int cnt;
      @(negedge clk);
      cnt = startCnt - 1 - (t - 1) / (int'(downGap) + 1);
      if (cnt < 0) cnt = 0;
      checkOutputs(tag, cnt, 1'b0);
      if (raise && t == 1) pulseReq = 1'b1;
    end
  endtask

  task automatic finishRun;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; pulseReq = 1'b1; fullCut = 1'b1;
    upGap = 8'd0; downGap = 8'd0; settleTime = 8'd0;
    repeat (3) @(negedge clk);
    checkOutputs("R1 reset", 0, 1'b0);
    pulseReq = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkOutputs("R1 idle after reset", 0, 1'b0);

    // Table walk: full power-up and power-down per vector.
    for (int v = 0; v < 4; v++) begin
      int readyAt;
      int offAt;
      upGap      = VEC[v][63:56];
      downGap    = VEC[v][55:48];
      settleTime = VEC[v][47:40];
      fullCut    = VEC[v][32];
      readyAt    = int'(VEC[v][31:16]);
      offAt      = int'(VEC[v][15:0]);
      @(negedge clk);
      prevOnes = 0;
      runUp(1, readyAt - 1, (upGap == 0) ? "R9 zero gap ramp-up" : "R2 ramp-up");
      checkEq("R4 not ready before settle", int'(ready), 0);
      runUp(readyAt, readyAt + 2, "R4 settled");
      checkEq("R4 ready held", int'(ready), 1);
      runDown(N, offAt + 2, "R3 ramp-down", 1'b0);
      checkEq("R3 all released", int'(colEnable), 0);
    end

    // Reversal part way through power-up.
    upGap = 8'd2; downGap = 8'd1; settleTime = 8'd4; fullCut = 1'b0;
    @(negedge clk);
    prevOnes = 0;
    runUp(1, 8, "R5 before reversal");
    runDown(3, 7, "R5 reversal", 1'b0);

    // Reversal with only the first column on.
    fullCut = 1'b1;
    @(negedge clk);
    prevOnes = 0;
    runUp(1, 1, "R5 first column up");
    runDown(1, 3, "R5 first column reversal", 1'b0);

    // Request raised again during power-down.
    upGap = 8'd0; downGap = 8'd2; settleTime = 8'd0;
    @(negedge clk);
    prevOnes = 0;
    runUp(1, 10, "R6 power-up");
    runDown(N, 22, "R6 ramp-down ignores request", 1'b1);
    @(negedge clk);
    checkOutputs("R6 restart after off", 1, 1'b0);
    @(negedge clk);
    checkOutputs("R6 restart continues", 2, 1'b0);

    finishRun();
  end

endmodule